// File: doc/BRIEF.md
# Multi-Type Thread Group Issue Scheduler

This block decides, cycle by cycle, which resident thread group of a 16-lane scalar shader cluster drives the lanes next. The lanes form two halves of eight that always carry the same instruction. A picked instruction stays on the halves for a number of cycles that depends on the group's kind: vertex, geometry or pixel. The active half alternates on each of those cycles. Groups of all three kinds may share the cluster at the same time. One group's instruction may follow another's in the very next cycle, so switching groups costs no extra cycles.

A launcher places a group into one of the slots with its kind. A group that has sent a texture fetch is marked as waiting and is skipped until the fetch return names its slot. Other groups keep issuing in the meantime. Slots are released by a retire strobe. A small table holds the per-kind cycle count and can be rewritten at run time.

Top module: `shader_issue_ctl`

## Requirements
- R1: While reset is low, and on the first cycle after it, `issue_valid` is 0. The round-robin search then begins at slot 0.
- R2: `alloc_valid` with a kind code of 00 (vertex), 01 (geometry) or 10 (pixel) makes the slot resident and not waiting from the next cycle. Code 11 is ignored and leaves the slot unchanged. If an allocation and a retirement name the same slot in one cycle, the allocation wins.
- R3: A picked instruction is shown for exactly L consecutive cycles. `issue_beat` counts 0 to L-1 with unchanged `issue_slot` and `issue_type`, where L is the table entry for the group's kind. After reset the entries are 2 for vertex, 2 for geometry and 4 for pixel.
- R4: `issue_half` is 0 on beat 0 and toggles on every following beat of the same instruction.
- R5: No new instruction starts before the current one's last beat. If a group is ready, the next instruction starts in the cycle right after that last beat, with no idle gap.
- R6: Among ready slots, the first one found searching upward (with wrap) from the slot after the last issued slot is picked, one cycle after the decision state.
- R7: A `wait_set_valid` strobe stops that slot from being picked from the next cycle on. Other ready slots keep issuing.
- R8: A `fetch_ret_valid` strobe clears the slot's waiting flag in the following cycle. If a wait set and a fetch return name the same slot in one cycle, the slot ends up waiting.
- R9: `retire_valid` makes the slot non-resident from the next cycle. An instruction already running from that slot completes all of its beats.
- R10: `cfg_we` with `cfg_sel` 0 (vertex), 1 (geometry) or 2 (pixel) loads `cfg_cycles` into that entry. It affects only instructions picked later. A value of 0 and a selector of 3 are ignored.
- R11: Groups of different kinds that are ready together interleave instruction by instruction, each with its own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Place a group into a slot |
| alloc_slot | input | 3 | Slot index for allocation |
| alloc_type | input | 2 | Kind code 00 vertex, 01 geometry, 10 pixel |
| retire_valid | input | 1 | Release a slot |
| retire_slot | input | 3 | Slot index to release |
| wait_set_valid | input | 1 | Mark a slot as waiting on a fetch |
| wait_set_slot | input | 3 | Slot index to mark |
| fetch_ret_valid | input | 1 | Fetch data returned for a slot |
| fetch_ret_slot | input | 3 | Slot index whose fetch returned |
| cfg_we | input | 1 | Write one cycle-count entry |
| cfg_sel | input | 2 | Entry selector 0 vertex, 1 geometry, 2 pixel |
| cfg_cycles | input | 4 | New cycle count |
| issue_valid | output | 1 | An instruction occupies the halves this cycle |
| issue_slot | output | 3 | Slot of the issuing group |
| issue_type | output | 2 | Kind of the issuing group |
| issue_half | output | 1 | Active lane half, 0 or 1 |
| issue_beat | output | 4 | Cycle index within the current instruction |

## Verification
A lone vertex group and a lone pixel group show the raw beat length and half toggling, with no arbitration involved. All eight slots filled with mixed kinds separate a correct wrap-around search from a fixed-priority one, and expose any idle gap at instruction boundaries. Waiting patterns come next: one slot waiting, all slots waiting, and a wait set that coincides with a fetch return. These separate correct stalling from a stall that blocks the whole cluster, and they confirm which update wins the same-cycle race. Table rewrites during a running pixel instruction, including a write of zero and a write to selector 3, separate capture-at-pick from a live table lookup.

// File: rtl/issue_pkg.sv
// Shared types for the shader cluster issue scheduler.
// Assumes the kind code is fixed at two bits; code 11 is reserved.
package issue_pkg;
    typedef enum logic [1:0] {
        KIND_VTX = 2'b00,
        KIND_GEO = 2'b01,
        KIND_PIX = 2'b10,
        KIND_RSV = 2'b11
    } grp_kind_e;
endpackage

// File: rtl/grp_slot_table.sv
// Per-slot residency, kind and fetch-wait state.
// Assumes slot indices are always below N_SLOTS. Allocation beats retirement;
// a wait set beats a fetch return on the same slot in the same cycle.
module grp_slot_table
    import issue_pkg::*;
#(
    parameter int N_SLOTS = 8,
    localparam int SW = $clog2(N_SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_valid,
    input  logic [SW-1:0]           alloc_slot,
    input  logic [1:0]              alloc_type,
    input  logic                    retire_valid,
    input  logic [SW-1:0]           retire_slot,
    input  logic                    wait_set_valid,
    input  logic [SW-1:0]           wait_set_slot,
    input  logic                    fetch_ret_valid,
    input  logic [SW-1:0]           fetch_ret_slot,
    output logic [N_SLOTS-1:0]      ready,
    output logic [N_SLOTS-1:0][1:0] kind
);
    logic alloc_ok;
    assign alloc_ok = alloc_valid && (alloc_type != KIND_RSV);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic resident;
        logic waiting;
        logic [1:0] kind_q;

        // Update one slot from the allocation, retire, wait and return strobes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                resident <= 1'b0;
                waiting  <= 1'b0;
                kind_q   <= KIND_VTX;
            end else if (alloc_ok && alloc_slot == SW'(g)) begin
                resident <= 1'b1;
                waiting  <= 1'b0;
                kind_q   <= alloc_type;
            end else begin
                if (retire_valid && retire_slot == SW'(g))
                    resident <= 1'b0;
                if (wait_set_valid && wait_set_slot == SW'(g))
                    waiting <= 1'b1;
                else if (fetch_ret_valid && fetch_ret_slot == SW'(g))
                    waiting <= 1'b0;
            end
        end

        assign ready[g] = resident && !waiting;
        assign kind[g]  = kind_q;
    end
endmodule

// File: rtl/kind_len_table.sv
// Programmable cycle count per group kind.
// Assumes at least one cycle per instruction: zero writes and selector 3 are dropped.
module kind_len_table #(
    parameter int BW      = 4,
    parameter int DEF_VTX = 2,
    parameter int DEF_GEO = 2,
    parameter int DEF_PIX = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [BW-1:0] cfg_cycles,
    input  logic [1:0]    rd_kind,
    output logic [BW-1:0] rd_len
);
    logic [2:0][BW-1:0] len_q;

    // Load defaults on reset and accept legal entry writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q[0] <= BW'(DEF_VTX);
            len_q[1] <= BW'(DEF_GEO);
            len_q[2] <= BW'(DEF_PIX);
        end else if (cfg_we && cfg_sel != 2'd3 && cfg_cycles != '0) begin
            len_q[cfg_sel] <= cfg_cycles;
        end
    end

    // Look up the entry for the kind of the slot being picked.
    always_comb begin
        rd_len = len_q[0];
        if (rd_kind == 2'd1) rd_len = len_q[1];
        if (rd_kind == 2'd2) rd_len = len_q[2];
    end
endmodule

// File: rtl/rr_ready_pick.sv
// Round-robin search over ready slots, starting just after the last issued one.
// Purely combinational; assumes last < N_SLOTS.
module rr_ready_pick #(
    parameter int N_SLOTS = 8,
    localparam int SW = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] ready,
    input  logic [SW-1:0]      last,
    output logic               found,
    output logic [SW-1:0]      pick
);
    // Scan slots in wrap-around order and keep the first ready one.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 1; i <= N_SLOTS; i++) begin
            int idx;
            idx = (int'(last) + i) % N_SLOTS;
            if (!found && ready[idx]) begin
                found = 1'b1;
                pick  = SW'(idx);
            end
        end
    end
endmodule

// File: rtl/beat_sequencer.sv
// Holds the running instruction and steps it through its beats and halves.
// A new pick is taken when idle or on the last beat, so group changes cost no cycle.
// Assumes pick_len is at least 1.
module beat_sequencer #(
    parameter int N_SLOTS = 8,
    parameter int BW      = 4,
    localparam int SW = $clog2(N_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          found,
    input  logic [SW-1:0] pick,
    input  logic [1:0]    pick_kind,
    input  logic [BW-1:0] pick_len,
    output logic          active,
    output logic [SW-1:0] cur_slot,
    output logic [1:0]    cur_kind,
    output logic [BW-1:0] cur_beat,
    output logic [BW-1:0] cur_len,
    output logic          cur_half,
    output logic [SW-1:0] last_slot
);
    logic last_beat;
    logic take;

    assign last_beat = active && (cur_beat == cur_len - 1'b1);
    assign take      = (!active || last_beat) && found;

    // Start a picked instruction, advance its beat, or go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cur_slot  <= '0;
            cur_kind  <= '0;
            cur_beat  <= '0;
            cur_len   <= BW'(1);
            cur_half  <= 1'b0;
            last_slot <= SW'(N_SLOTS - 1);
        end else if (take) begin
            active    <= 1'b1;
            cur_slot  <= pick;
            cur_kind  <= pick_kind;
            cur_beat  <= '0;
            cur_len   <= pick_len;
            cur_half  <= 1'b0;
            last_slot <= pick;
        end else if (active && !last_beat) begin
            cur_beat  <= cur_beat + 1'b1;
            cur_half  <= ~cur_half;
        end else begin
            active    <= 1'b0;
        end
    end
endmodule

// File: rtl/shader_issue_ctl.sv
// Issue control for a 16-lane cluster split into two 8-lane halves.
// Ties together the slot table, the round-robin picker, the length table
// and the beat sequencer. Assumes N_SLOTS is a power of two.
module shader_issue_ctl #(
    parameter int N_SLOTS = 8,
    parameter int MAX_CYC = 8,
    parameter int DEF_VTX = 2,
    parameter int DEF_GEO = 2,
    parameter int DEF_PIX = 4,
    localparam int SW = $clog2(N_SLOTS),
    localparam int BW = $clog2(MAX_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [SW-1:0] alloc_slot,
    input  logic [1:0]    alloc_type,
    input  logic          retire_valid,
    input  logic [SW-1:0] retire_slot,
    input  logic          wait_set_valid,
    input  logic [SW-1:0] wait_set_slot,
    input  logic          fetch_ret_valid,
    input  logic [SW-1:0] fetch_ret_slot,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [BW-1:0] cfg_cycles,
    output logic          issue_valid,
    output logic [SW-1:0] issue_slot,
    output logic [1:0]    issue_type,
    output logic          issue_half,
    output logic [BW-1:0] issue_beat
);
    logic [N_SLOTS-1:0]      ready;
    logic [N_SLOTS-1:0][1:0] kind;
    logic                    found;
    logic [SW-1:0]           pick;
    logic [SW-1:0]           last_slot;
    logic [BW-1:0]           pick_len;
    logic [BW-1:0]           cur_len;

    grp_slot_table #(.N_SLOTS(N_SLOTS)) slots_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_slot(alloc_slot), .alloc_type(alloc_type),
        .retire_valid(retire_valid), .retire_slot(retire_slot),
        .wait_set_valid(wait_set_valid), .wait_set_slot(wait_set_slot),
        .fetch_ret_valid(fetch_ret_valid), .fetch_ret_slot(fetch_ret_slot),
        .ready(ready), .kind(kind)
    );

    rr_ready_pick #(.N_SLOTS(N_SLOTS)) pick_i (
        .ready(ready), .last(last_slot), .found(found), .pick(pick)
    );

    kind_len_table #(.BW(BW), .DEF_VTX(DEF_VTX), .DEF_GEO(DEF_GEO), .DEF_PIX(DEF_PIX)) lens_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_cycles(cfg_cycles),
        .rd_kind(kind[pick]), .rd_len(pick_len)
    );

    beat_sequencer #(.N_SLOTS(N_SLOTS), .BW(BW)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .found(found), .pick(pick), .pick_kind(kind[pick]), .pick_len(pick_len),
        .active(issue_valid), .cur_slot(issue_slot), .cur_kind(issue_type),
        .cur_beat(issue_beat), .cur_len(cur_len), .cur_half(issue_half),
        .last_slot(last_slot)
    );
endmodule

// File: rtl/shader_issue_ctl_chk.sv
// Property checker for the issue scheduler, attached with bind.
// Observes the outputs plus the slot readiness and running instruction length.
module shader_issue_ctl_chk #(
    parameter int N_SLOTS = 8,
    parameter int BW      = 4,
    localparam int SW = $clog2(N_SLOTS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_valid,
    input logic [SW-1:0]      issue_slot,
    input logic [1:0]         issue_type,
    input logic               issue_half,
    input logic [BW-1:0]      issue_beat,
    input logic [BW-1:0]      cur_len,
    input logic [N_SLOTS-1:0] ready
);
    logic [N_SLOTS-1:0] ready_q;

    // Keep last cycle's readiness to judge each new start.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= '0;
        else        ready_q <= ready;
    end

    AST_NO_RSV_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> issue_type != 2'b11); // R2

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_beat != '0) |->
            ($past(issue_valid) && issue_beat == BW'($past(issue_beat) + 1'b1)
             && issue_slot == $past(issue_slot) && issue_type == $past(issue_type))); // R3

    AST_HALF_START: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_beat == '0) |-> !issue_half); // R4

    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_beat != '0) |-> issue_half != $past(issue_half)); // R4

    AST_HOLD_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_beat != cur_len - 1'b1) |=>
            (issue_valid && issue_beat != '0)); // R5

    AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_beat == '0) |-> ready_q[issue_slot]); // R7
endmodule

bind shader_issue_ctl shader_issue_ctl_chk #(.N_SLOTS(N_SLOTS), .BW(BW)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_slot(issue_slot), .issue_type(issue_type),
    .issue_half(issue_half), .issue_beat(issue_beat),
    .cur_len(cur_len), .ready(ready)
);

// File: tb/shader_issue_ctl_tb.sv
// Bench: behavioural reference model stepped on every clock and compared at the falling edge.
module shader_issue_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0, retire_valid = 0, wait_set_valid = 0, fetch_ret_valid = 0, cfg_we = 0;
    logic [2:0] alloc_slot = 0, retire_slot = 0, wait_set_slot = 0, fetch_ret_slot = 0;
    logic [1:0] alloc_type = 0, cfg_sel = 0;
    logic [3:0] cfg_cycles = 0;
    logic issue_valid, issue_half;
    logic [2:0] issue_slot;
    logic [1:0] issue_type;
    logic [3:0] issue_beat;

    int n_tests = 0, n_fail = 0;
    string req_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    shader_issue_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_slot(alloc_slot), .alloc_type(alloc_type),
        .retire_valid(retire_valid), .retire_slot(retire_slot),
        .wait_set_valid(wait_set_valid), .wait_set_slot(wait_set_slot),
        .fetch_ret_valid(fetch_ret_valid), .fetch_ret_slot(fetch_ret_slot),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_cycles(cfg_cycles),
        .issue_valid(issue_valid), .issue_slot(issue_slot), .issue_type(issue_type),
        .issue_half(issue_half), .issue_beat(issue_beat)
    );

    // Reference model state
    bit m_res[NS], m_wait[NS];
    int m_kind[NS];
    int m_len[3];
    bit m_act;
    int m_slot, m_kindc, m_beat, m_curlen, m_last;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_res[i]) begin m_res[i] = 0; m_wait[i] = 0; m_kind[i] = 0; end
            m_len[0] = 2; m_len[1] = 2; m_len[2] = 4;
            m_act = 0; m_slot = 0; m_kindc = 0; m_beat = 0; m_curlen = 1; m_last = NS - 1;
        end else begin
            int sel;
            sel = -1;
            if (!m_act || m_beat == m_curlen - 1) begin
                for (int i = 1; i <= NS; i++) begin
                    int k;
                    k = (m_last + i) % NS;
                    if (sel < 0 && m_res[k] && !m_wait[k]) sel = k;
                end
            end
            if (sel >= 0) begin
                m_act = 1; m_slot = sel; m_kindc = m_kind[sel]; m_beat = 0;
                m_curlen = m_len[m_kind[sel]]; m_last = sel;
            end else if (m_act && m_beat < m_curlen - 1) begin
                m_beat++;
            end else begin
                m_act = 0;
            end
            if (alloc_valid && alloc_type != 2'b11) begin
                m_res[alloc_slot] = 1; m_wait[alloc_slot] = 0; m_kind[alloc_slot] = int'(alloc_type);
            end
            for (int s = 0; s < NS; s++) begin
                if (!(alloc_valid && alloc_type != 2'b11 && int'(alloc_slot) == s)) begin
                    if (retire_valid && int'(retire_slot) == s) m_res[s] = 0;
                    if (wait_set_valid && int'(wait_set_slot) == s) m_wait[s] = 1;
                    else if (fetch_ret_valid && int'(fetch_ret_slot) == s) m_wait[s] = 0;
                end
            end
            if (cfg_we && cfg_sel != 2'd3 && cfg_cycles != 0) m_len[cfg_sel] = int'(cfg_cycles);
        end
    end

    task automatic check(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req_tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        check("issue_valid", int'(issue_valid), int'(m_act));
        if (m_act) begin
            check("issue_slot", int'(issue_slot), m_slot);
            check("issue_type", int'(issue_type), m_kindc);
            check("issue_beat", int'(issue_beat), m_beat);
            check("issue_half", int'(issue_half), m_beat % 2);
        end
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
            alloc_valid = 0; retire_valid = 0; wait_set_valid = 0; fetch_ret_valid = 0; cfg_we = 0;
        end
    endtask

    task automatic do_alloc(int s, int t);
        alloc_valid = 1; alloc_slot = 3'(s); alloc_type = 2'(t);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seen;
        // R1: reset holds issue idle
        req_tag = "R1";
        repeat (3) @(negedge clk);
        check("issue_valid in reset", int'(issue_valid), 0);
        rst_n = 1;
        cyc(1);
        check("issue_valid after reset", int'(issue_valid), 0);

        // R2: reserved kind ignored, then a legal allocation
        req_tag = "R2";
        do_alloc(5, 3); cyc(5);
        check("reserved kind leaves idle", int'(issue_valid), 0);
        do_alloc(0, 0); cyc(1);
        cyc(1);
        check("vertex slot issues", int'(issue_valid && issue_slot == 0), 1);

        // R3 R4: lone vertex and pixel lengths and halves
        req_tag = "R3";
        cyc(6);
        retire_valid = 1; retire_slot = 0; cyc(4);
        req_tag = "R4";
        do_alloc(2, 2); cyc(12);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            if (issue_valid && issue_beat == 3) seen++;
        end
        check("pixel beat 3 seen", int'(seen > 0), 1);

        // R6 R11 R5: all slots with mixed kinds
        req_tag = "R11";
        for (int s = 0; s < NS; s++) begin do_alloc(s, s % 3); cyc(1); end
        req_tag = "R6";
        cyc(30);
        req_tag = "R5";
        cyc(20);

        // R7: one slot waits, others continue
        req_tag = "R7";
        wait_set_valid = 1; wait_set_slot = 3; cyc(40);
        // R8: return clears; same-cycle set and return leaves waiting
        req_tag = "R8";
        fetch_ret_valid = 1; fetch_ret_slot = 3; cyc(20);
        wait_set_valid = 1; wait_set_slot = 4; fetch_ret_valid = 1; fetch_ret_slot = 4; cyc(40);
        fetch_ret_valid = 1; fetch_ret_slot = 4; cyc(10);
        // R7: every slot waiting stalls, returns resume
        req_tag = "R7";
        for (int s = 0; s < NS; s++) begin wait_set_valid = 1; wait_set_slot = 3'(s); cyc(1); end
        cyc(8);
        check("all waiting idle", int'(issue_valid), 0);
        req_tag = "R8";
        fetch_ret_valid = 1; fetch_ret_slot = 6; cyc(10);
        for (int s = 0; s < NS; s++) begin fetch_ret_valid = 1; fetch_ret_slot = 3'(s); cyc(1); end

        // R9: retire mid instruction, alloc beats retire
        req_tag = "R9";
        cyc(3);
        retire_valid = 1; retire_slot = issue_slot; cyc(15);
        do_alloc(1, 2); retire_valid = 1; retire_slot = 1; cyc(25);

        // R10: table rewrites during a running pixel instruction
        req_tag = "R10";
        for (int s = 0; s < NS; s++) begin retire_valid = 1; retire_slot = 3'(s); cyc(1); end
        cyc(6);
        do_alloc(2, 2); cyc(2);
        cfg_we = 1; cfg_sel = 2; cfg_cycles = 3; cyc(1);
        cfg_we = 1; cfg_sel = 0; cfg_cycles = 0; cyc(1);
        cfg_we = 1; cfg_sel = 3; cfg_cycles = 7; cyc(1);
        do_alloc(5, 0); cyc(1);
        cfg_we = 1; cfg_sel = 1; cfg_cycles = 5; cyc(1);
        do_alloc(6, 1); cyc(30);
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            if (issue_valid && issue_slot == 2 && issue_beat == 3) seen++;
        end
        check("pixel length now 3", seen, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule